// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a small on-chip table of VLAN entries. Each entry holds a 13-bit VLAN identifier, an 8-bit forwarding-database number and a 4-bit field per port. A host reaches the block through a window of 16-bit registers. It stages an identifier, a valid flag and per-port data in the window, then writes a command word with its busy bit set. The engine runs the command against the table and clears busy when the command is done. The host polls the busy bit before it issues anything further.

There are three commands. Load/purge adds, overwrites or removes the entry for the staged identifier. Get-next finds the lowest valid identifier strictly above the staged one and returns that entry in the window. Flush-all empties the table. Get-next leaves the identifier it returned in the identifier register, so repeated get-next commands walk the table in ascending order. Load/purge and get-next scan the table one entry per clock. Flush-all completes in a single cycle.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset, the command word, the identifier register and every data register read zero, and the table holds no valid entry.
- R2: A command starts only when the command word (address 0) is written with bit 15 set. Bit 15 then reads 1 until the command completes. A command-word write with bit 15 clear changes nothing. The opcode sits in bits 14:12: 1 is flush-all, 3 is load/purge and 4 is get-next.
- R3: While busy reads 1, writes to any register are ignored.
- R4: The identifier register (address 1) holds identifier bits 11:0 in bits 11:0, the valid flag in bit 12 and identifier bit 12 in bit 13. Other bits read zero, and the register reads back what was written.
- R5: Load/purge with the valid flag set creates the entry for the staged identifier, or overwrites it if it already exists. The entry takes the staged database number and the staged per-port data.
- R6: Load/purge with the valid flag clear removes the entry for the staged identifier. If there is no such entry, the table does not change.
- R7: Get-next returns the lowest valid identifier strictly greater than the staged one. It places that identifier in the identifier register with the valid flag set, so a second get-next continues the walk without any register write.
- R8: If no valid entry lies above the staged identifier, get-next leaves the valid flag clear and sets the identifier to all ones (the register reads 0x2FFF).
- R9: Per-port data occupies data registers at addresses 2, 3 and 4. Port i uses register 2 + i/4 at bit offset (i%4)*4, with the member tag in the low two bits and the port state in the high two bits. Load stores these bits, and a get-next hit returns them in the same positions.
- R10: Database bits 3:0 sit in command-word bits 3:0 and database bits 7:4 sit in command-word bits 11:8. Command-word bits 7:4 read zero. Load takes the database number from these fields, and a get-next hit returns it there.
- R11: Flush-all invalidates every entry.
- R12: When every slot holds a valid entry, loading a new identifier leaves the table unchanged. Existing entries can still be overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 16 | Read data, combinational from `reg_raddr` |

## Verification
Directed cases stage identifiers that set bit 12 (the page bit), byte-wide database numbers and distinct per-port patterns. Reading these back shows whether the identifier, database and port fields stay in their own positions. Random mixes of loads, purges, fresh get-next searches and continued walks run over a narrow identifier range, plus the values 0, 4095, 4096 and 8190. This makes overwrites, purges of absent entries and a full table all occur; the extreme identifiers also test that comparisons and misses behave correctly at the top of the identifier space. Writes issued while a command is in progress, and a command-word write with busy clear, test that only the intended path changes state.

// File: rtl/vlan_cmd_pkg.sv
package vlan_cmd_pkg;
    localparam int REG_W   = 16;
    localparam int ADDR_W  = 3;
    localparam int VID_W   = 13;
    localparam int DB_W    = 8;

    localparam logic [ADDR_W-1:0] A_CMD   = 3'd0;
    localparam logic [ADDR_W-1:0] A_VID   = 3'd1;
    localparam logic [ADDR_W-1:0] A_DATA0 = 3'd2;

    localparam int BUSY_BIT  = 15;
    localparam int VALID_BIT = 12;
    localparam int PAGE_BIT  = 13;

    localparam logic [2:0] OPC_FLUSH = 3'd1;
    localparam logic [2:0] OPC_LOAD  = 3'd3;
    localparam logic [2:0] OPC_NEXT  = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } eng_st_e;
endpackage

// File: rtl/vlan_table.sv
module vlan_table #(
    parameter int DEPTH = 64,
    parameter int ENT_W = 69,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic             wr_valid,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_ent,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [ENT_W-1:0] rd_ent
);
    logic [DEPTH-1:0] valid_q;
    logic [ENT_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= '0;
        else if (flush) valid_q <= '0;
        else if (wr_en) valid_q[wr_idx] <= wr_valid;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_ent;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_ent   = mem_q[rd_idx];

    // Flush-all must leave no valid slot behind (R11)
    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
endmodule

// File: rtl/vlan_cmd_ctrl.sv
module vlan_cmd_ctrl
    import vlan_cmd_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int NUM_PORTS = 12,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int PORT_BITS = NUM_PORTS * 4,
    localparam int NUM_DREGS = (PORT_BITS + REG_W - 1) / REG_W,
    localparam int DREG_BITS = NUM_DREGS * REG_W,
    localparam int ENT_W     = VID_W + DB_W + PORT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [IDX_W-1:0]  tbl_rd_idx,
    input  logic              tbl_rd_valid,
    input  logic [ENT_W-1:0]  tbl_rd_ent,
    output logic              tbl_wr_en,
    output logic              tbl_wr_valid,
    output logic [IDX_W-1:0]  tbl_wr_idx,
    output logic [ENT_W-1:0]  tbl_wr_ent,
    output logic              tbl_flush
);
    typedef struct packed {
        eng_st_e              st;
        logic [2:0]           opc;
        logic [DB_W-1:0]      db;
        logic [VID_W-1:0]     vid;
        logic                 vvalid;
        logic [DREG_BITS-1:0] pdata;
        logic [IDX_W-1:0]     idx;
        logic                 hit;
        logic [IDX_W-1:0]     hit_idx;
        logic [VID_W-1:0]     best_vid;
        logic                 free_ok;
        logic [IDX_W-1:0]     free_idx;
    } eng_s_t;

    eng_s_t s_q, s_d;
    logic busy;
    logic [VID_W-1:0] ent_vid;
    logic [DB_W-1:0]  ent_db;

    assign busy    = (s_q.st != ST_IDLE);
    assign ent_vid = tbl_rd_ent[PORT_BITS+DB_W +: VID_W];
    assign ent_db  = tbl_rd_ent[PORT_BITS +: DB_W];

    always_comb begin
        s_d          = s_q;
        tbl_flush    = 1'b0;
        tbl_wr_en    = 1'b0;
        tbl_wr_valid = s_q.vvalid;
        tbl_wr_idx   = s_q.hit_idx;
        tbl_wr_ent   = {s_q.vid, s_q.db, s_q.pdata[PORT_BITS-1:0]};
        tbl_rd_idx   = s_q.idx;
        case (s_q.st)
            ST_IDLE: begin
                if (reg_wr_en) begin
                    if (reg_addr == A_CMD) begin
                        if (reg_wdata[BUSY_BIT]) begin
                            s_d.opc     = reg_wdata[14:12];
                            s_d.db      = {reg_wdata[11:8], reg_wdata[3:0]};
                            s_d.st      = ST_SCAN;
                            s_d.idx     = '0;
                            s_d.hit     = 1'b0;
                            s_d.free_ok = 1'b0;
                        end
                    end else if (reg_addr == A_VID) begin
                        s_d.vid    = {reg_wdata[PAGE_BIT], reg_wdata[11:0]};
                        s_d.vvalid = reg_wdata[VALID_BIT];
                    end else begin
                        for (int k = 0; k < NUM_DREGS; k++) begin
                            if (reg_addr == A_DATA0 + ADDR_W'(k))
                                s_d.pdata[k*REG_W +: REG_W] = reg_wdata;
                        end
                    end
                end
            end
            ST_SCAN: begin
                if (s_q.opc == OPC_FLUSH) begin
                    tbl_flush = 1'b1;
                    s_d.st    = ST_IDLE;
                end else if (s_q.opc != OPC_LOAD && s_q.opc != OPC_NEXT) begin
                    s_d.st = ST_IDLE;
                end else begin
                    if (s_q.opc == OPC_LOAD) begin
                        if (tbl_rd_valid && ent_vid == s_q.vid && !s_q.hit) begin
                            s_d.hit     = 1'b1;
                            s_d.hit_idx = s_q.idx;
                        end
                        if (!tbl_rd_valid && !s_q.free_ok) begin
                            s_d.free_ok  = 1'b1;
                            s_d.free_idx = s_q.idx;
                        end
                    end else if (tbl_rd_valid && ent_vid > s_q.vid &&
                                 (!s_q.hit || ent_vid < s_q.best_vid)) begin
                        s_d.hit      = 1'b1;
                        s_d.hit_idx  = s_q.idx;
                        s_d.best_vid = ent_vid;
                    end
                    if (s_q.idx == IDX_W'(DEPTH - 1)) s_d.st = ST_DONE;
                    else                              s_d.idx = s_q.idx + 1'b1;
                end
            end
            default: begin
                tbl_rd_idx = s_q.hit_idx;
                s_d.st     = ST_IDLE;
                if (s_q.opc == OPC_LOAD) begin
                    if (s_q.hit) begin
                        tbl_wr_en = 1'b1;
                    end else if (s_q.vvalid && s_q.free_ok) begin
                        tbl_wr_en  = 1'b1;
                        tbl_wr_idx = s_q.free_idx;
                    end
                end else if (s_q.hit) begin
                    s_d.vid    = ent_vid;
                    s_d.vvalid = 1'b1;
                    s_d.db     = ent_db;
                    s_d.pdata  = DREG_BITS'(tbl_rd_ent[PORT_BITS-1:0]);
                end else begin
                    s_d.vid    = '1;
                    s_d.vvalid = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_raddr == A_CMD) begin
            reg_rdata = {busy, s_q.opc, s_q.db[7:4], 4'b0000, s_q.db[3:0]};
        end else if (reg_raddr == A_VID) begin
            reg_rdata = {2'b00, s_q.vid[12], s_q.vvalid, s_q.vid[11:0]};
        end else begin
            for (int k = 0; k < NUM_DREGS; k++) begin
                if (reg_raddr == A_DATA0 + ADDR_W'(k))
                    reg_rdata = s_q.pdata[k*REG_W +: REG_W];
            end
        end
    end

    assert_start_needs_busy_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr_en && reg_addr == A_CMD && reg_wdata[BUSY_BIT]));

    assert_busy_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && s_q.opc != OPC_NEXT && reg_wr_en && reg_addr == A_VID)
        |=> $stable({s_q.vid, s_q.vvalid}));

    assert_next_ascends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DONE && s_q.opc == OPC_NEXT && s_q.hit)
        |=> (s_q.vvalid && s_q.vid > $past(s_q.vid)));

    assert_next_miss_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DONE && s_q.opc == OPC_NEXT && !s_q.hit)
        |=> (!s_q.vvalid && (&s_q.vid)));
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
    import vlan_cmd_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int NUM_PORTS = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    input  logic [2:0]  reg_raddr,
    output logic [15:0] reg_rdata
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int ENT_W = VID_W + DB_W + NUM_PORTS * 4;

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic             rd_valid, wr_en, wr_valid, flush;
    logic [ENT_W-1:0] rd_ent, wr_ent;

    vlan_cmd_ctrl #(.DEPTH(DEPTH), .NUM_PORTS(NUM_PORTS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .tbl_rd_idx(rd_idx), .tbl_rd_valid(rd_valid), .tbl_rd_ent(rd_ent),
        .tbl_wr_en(wr_en), .tbl_wr_valid(wr_valid), .tbl_wr_idx(wr_idx),
        .tbl_wr_ent(wr_ent), .tbl_flush(flush)
    );

    vlan_table #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_table (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(wr_en), .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_ent(wr_ent),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_ent(rd_ent)
    );
endmodule

// File: tb/test_vlan_cmd_engine.sv
module test_vlan_cmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [15:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]  m_db [int];
    logic [47:0] m_pt [int];
    logic [12:0] sh_vid = '0;
    logic [7:0]  sh_db = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlan_cmd_engine i_vlan_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
    );

    function automatic logic [15:0] vid_word(logic [12:0] v, logic val);
        return {2'b00, v[12], val, v[11:0]};
    endfunction

    function automatic logic [15:0] cmd_word(logic [2:0] opc, logic [7:0] db, logic busy);
        return {busy, opc, db[7:4], 4'b0000, db[3:0]};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_raddr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        v = 16'h8000;
        for (int i = 0; i < 300; i++) begin
            rd(3'd0, v);
            if (!v[15]) break;
        end
        if (v[15]) chk("R2 busy never cleared", 64'(v[15]), 64'd0);
    endtask

    task automatic cmd(logic [2:0] opc);
        logic [15:0] v;
        wr(3'd0, cmd_word(opc, sh_db, 1'b1));
        if (opc != 3'd1) begin
            rd(3'd0, v);
            chk("R2 busy set while running", 64'(v[15]), 64'd1);
        end
        wait_idle();
    endtask

    task automatic stage(logic [12:0] v, logic val, logic [47:0] p);
        wr(3'd1, vid_word(v, val));
        wr(3'd2, p[15:0]);
        wr(3'd3, p[31:16]);
        wr(3'd4, p[47:32]);
        sh_vid = v;
    endtask

    task automatic model_load(logic [12:0] v, logic val, logic [7:0] db, logic [47:0] p);
        int key;
        key = int'(v);
        if (val) begin
            if (m_db.exists(key) || m_db.num() < DEPTH) begin
                m_db[key] = db; m_pt[key] = p;
            end
        end else if (m_db.exists(key)) begin
            m_db.delete(key); m_pt.delete(key);
        end
    endtask

    task automatic do_load(logic [12:0] v, logic val, logic [7:0] db, logic [47:0] p);
        logic [15:0] r;
        stage(v, val, p);
        sh_db = db;
        cmd(3'd3);
        model_load(v, val, db, p);
        rd(3'd1, r);
        chk("R4 identifier register holds staged value", 64'(r), 64'(vid_word(v, val)));
    endtask

    task automatic do_next(bit rewrite, logic [12:0] start);
        logic [15:0] r, d0, d1, d2, c;
        int found;
        if (rewrite) begin
            wr(3'd1, vid_word(start, 1'b0));
            sh_vid = start;
        end
        cmd(3'd4);
        found = -1;
        for (int k = int'(sh_vid) + 1; k < 8192; k++) begin
            if (m_db.exists(k)) begin found = k; break; end
        end
        rd(3'd1, r);
        if (found < 0) begin
            chk("R8 miss leaves flag clear and ones", 64'(r), 64'h2FFF);
            sh_vid = 13'h1FFF;
        end else begin
            chk("R7 next higher identifier", 64'(r), 64'(vid_word(13'(found), 1'b1)));
            rd(3'd2, d0); rd(3'd3, d1); rd(3'd4, d2);
            chk("R9 port nibbles returned", 64'({d2, d1, d0}), 64'(m_pt[found]));
            rd(3'd0, c);
            chk("R10 database split fields", 64'(c & 16'h0F0F),
                64'({4'h0, m_db[found][7:4], 4'h0, m_db[found][3:0]}));
            sh_vid = 13'(found);
            sh_db  = m_db[found];
        end
    endtask

    task automatic do_flush();
        cmd(3'd1);
        m_db.delete(); m_pt.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic [12:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(3'd0, r); chk("R1 command word reset", 64'(r), 64'd0);
        rd(3'd1, r); chk("R1 identifier reset", 64'(r), 64'd0);
        rd(3'd2, r); chk("R1 data reset", 64'(r), 64'd0);
        do_next(1'b1, 13'd0);   // R1 empty table, R8 miss

        // R4/R5/R9/R10: page bit, split database, port nibbles
        do_load(13'h1005, 1'b1, 8'hA5, 48'h123456789ABC);
        do_load(13'h0007, 1'b1, 8'h3C, 48'hFEDCBA987654);
        do_next(1'b1, 13'h1004);
        do_next(1'b1, 13'h0000);
        do_next(1'b0, 13'h0000);   // R7 continue walk without rewrite
        do_next(1'b0, 13'h0000);   // R8 walk ends
        do_load(13'h0007, 1'b1, 8'h81, 48'h000F000F000F);  // R5 overwrite
        do_next(1'b1, 13'h0006);

        // R2: command-word write with busy clear changes nothing
        stage(13'd200, 1'b1, 48'h1);
        wr(3'd0, cmd_word(3'd3, 8'h11, 1'b0));
        rd(3'd0, r); chk("R2 no start without busy bit", 64'(r[15]), 64'd0);
        do_next(1'b1, 13'd199);

        // R3: writes during busy are ignored
        stage(13'd50, 1'b1, 48'h0000_5555_AAAA);
        sh_db = 8'h42;
        wr(3'd0, cmd_word(3'd3, sh_db, 1'b1));
        wr(3'd1, vid_word(13'd77, 1'b1));
        wr(3'd2, 16'hFFFF);
        wait_idle();
        model_load(13'd50, 1'b1, 8'h42, 48'h0000_5555_AAAA);
        rd(3'd1, r); chk("R3 identifier write during busy ignored", 64'(r), 64'(vid_word(13'd50, 1'b1)));
        rd(3'd2, r); chk("R3 data write during busy ignored", 64'(r), 64'hAAAA);
        do_next(1'b1, 13'd49);
        do_next(1'b1, 13'd76);

        // R6: purge existing and absent identifiers
        do_load(13'h1005, 1'b0, 8'h00, 48'h0);
        do_load(13'd999, 1'b0, 8'h00, 48'h0);
        do_next(1'b1, 13'h1004);
        do_next(1'b1, 13'd0);

        // R11: flush
        do_flush();
        do_next(1'b1, 13'd0);

        // R12: full table
        for (int i = 1; i <= DEPTH; i++)
            do_load(13'(i), 1'b1, 8'(i), {16'(i), 16'(i * 3), 16'(i * 7)});
        do_load(13'd100, 1'b1, 8'hEE, 48'hAB);
        do_next(1'b1, 13'(DEPTH));     // R12 new identifier refused
        do_load(13'd10, 1'b1, 8'h99, 48'h999);  // R12 overwrite still allowed
        do_next(1'b1, 13'd9);
        do_flush();

        // Random mix with boundary identifiers
        for (int n = 0; n < 250; n++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if ($urandom_range(0, 9) == 0) begin
                case ($urandom_range(0, 3))
                    0: v = 13'd0;
                    1: v = 13'd4095;
                    2: v = 13'd4096;
                    default: v = 13'd8190;
                endcase
            end else begin
                v = 13'($urandom_range(1, 80));
            end
            if (op <= 5)      do_load(v, 1'b1, 8'($urandom), {16'($urandom), $urandom});
            else if (op == 6) do_load(v, 1'b0, 8'h00, 48'h0);
            else if (op <= 8) do_next(1'b1, v);
            else for (int s = 0; s < 3; s++) do_next(1'b0, 13'd0);
        end
        do_next(1'b1, 13'h1FFF);   // R8 start at top of range

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule